// File: doc/BRIEF.md
# Reconfigurable Cipher Accelerator Life-Cycle Controller

This block sequences a reconfigurable cryptographic accelerator for a host processor. After reset it asks a system security monitor for the current battery and channel condition. It then publishes a mask of the implementation variants those conditions allow, and waits for the host to commit a parameter choice. The choice holds a key-size code, a reliability level and a performance policy. The controller turns that choice into a configuration index and launches a datapath reconfiguration through a start/done handshake. Once the datapath reports completion, it runs the primitive. The host can park the primitive in an idle state and resume it without a reload.

While running, the controller asks the monitor for fresh conditions at a programmable interval. Under the best-effort policy it moves to an energy-saving variant when either threshold is crossed, and back when both recover. Under the guaranteed-throughput policy the thresholds are ignored. A security event from the monitor preempts every state. It reloads the datapath with an index supplied by the monitor, adjusted to the attack class, and for a secret-extraction attack it also stalls the primitive's I/O until the host releases it.

Top module: `accel_life_ctrl`

## Requirements
- R1: After reset the status register reads state code 0, active index 0 and permitted mask 0. `mon_req` is high, and `rcfg_start` and `io_stall` are low.
- R2: In state 0 (querying) a `mon_ack` moves the controller to state 1 (awaiting choice) and drops `mon_req`. The permitted mask is bit0 = neither threshold low, bit1 = 1, bit2 = !battery-low, bit3 = !battery-low.
- R3: A write to the choice register (address 0: key code bits [KEY_W-1:0], reliability [9:8], policy bit 12 with 1 = guaranteed) in state 1 or 4 enters state 2. Two cycles after the write, a one-cycle `rcfg_start` carries index {reliability, key, eco}, with eco in bit 0. A `rcfg_done` after the start pulse enters state 3 (run) and makes that index the active one.
- R4: In run, `mon_req` rises exactly N cycles after run is entered, where N is the value in the poll register (address 1). N = 0 disables polling.
- R5: Under the best-effort policy, a poll answer with either threshold low that differs from the active index reconfigures with eco = 1. An answer with neither threshold low reconfigures with eco = 0.
- R6: Under the guaranteed-throughput policy the eco bit is always 0, and a poll whose target equals the active index causes no reconfiguration and stays in run.
- R7: Command bit 1 (address 2) moves run to state 4 (stop). Command bit 0 moves stop back to run with no `rcfg_start` and the active index unchanged.
- R8: `sec_evt` in any state, including state 2, enters state 2 on the next edge with a `rcfg_start`, and takes priority over host commands in the same cycle. For class 0 (hijack) the index is `sec_cfg` unchanged.
- R9: For class 1 (denial of service) the launched index is `sec_cfg` with its reliability field [4:3] forced to 2 (fault tolerance).
- R10: Class 2 (extraction) sets `io_stall` on the next edge. It stays set through the reload until a command with bit 2 is written.
- R11: A reliability code of 3 written to the choice register is stored and used as 2.
- R12: After a security-driven reload completes, the next poll answer re-applies the host choice and policy, reconfiguring if the target differs.
- R13: The status register (address 3) holds the state in [2:0], the active index at bit 8 upward, the permitted mask in [27:24] and `io_stall` in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr |
| mon_req | output | 1 | Status request to the monitor (level) |
| mon_ack | input | 1 | Monitor answer strobe |
| mon_batt_low | input | 1 | Battery below threshold, valid with mon_ack |
| mon_chan_low | input | 1 | Channel quality below threshold, valid with mon_ack |
| sec_evt | input | 1 | Security event pulse |
| sec_class | input | 2 | Attack class: 0 hijack, 1 denial of service, 2 extraction |
| sec_cfg | input | KEY_W+3 | Index chosen by the monitor |
| rcfg_start | output | 1 | One-cycle reconfiguration start |
| rcfg_idx | output | KEY_W+3 | Index to load |
| rcfg_done | input | 1 | Reconfiguration finished |
| io_stall | output | 1 | Stall the primitive's I/O |

## Verification
The launch path is driven four ways. A host choice exercises index packing and the clamp. A poll answer under each policy, with and without a crossed threshold, separates downgrade, upgrade and keep. A security pulse of each class separates the plain, forced-reliability and stalling responses. A pulse during a pending reload and a pulse coinciding with a stop command show that the security path preempts. Every expected launch index goes into a scoreboard queue, so an unexpected launch, one that is missing and one that carries the wrong index are all caught. Stop/resume and the guaranteed policy must produce no launch at all.

// File: rtl/accel_life_pkg.sv
package accel_life_pkg;
  typedef enum logic [2:0] {
    ST_INIT_Q = 3'd0,
    ST_INIT_W = 3'd1,
    ST_CFG    = 3'd2,
    ST_RUN    = 3'd3,
    ST_STOP   = 3'd4
  } life_state_e;

  localparam logic [1:0] ATK_HIJACK  = 2'd0;
  localparam logic [1:0] ATK_DOS     = 2'd1;
  localparam logic [1:0] ATK_EXTRACT = 2'd2;

  localparam logic [1:0] REL_NONE     = 2'd0;
  localparam logic [1:0] REL_DETECT   = 2'd1;
  localparam logic [1:0] REL_TOLERANT = 2'd2;

  localparam logic [1:0] A_CHOICE = 2'd0;
  localparam logic [1:0] A_POLL   = 2'd1;
  localparam logic [1:0] A_CMD    = 2'd2;
  localparam logic [1:0] A_STATUS = 2'd3;
endpackage

// File: rtl/alc_regs.sv
module alc_regs
  import accel_life_pkg::*;
#(
  parameter int KEY_W  = 2,
  parameter int POLL_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] rdata,
  output logic [KEY_W-1:0]  key_o,
  output logic [1:0]        rel_o,
  output logic              guar_o,
  output logic [POLL_W-1:0] interval_o,
  output logic              go_o,
  output logic              run_o,
  output logic              stop_o,
  output logic              release_o
);
  logic wr_choice, wr_poll, wr_cmd;
  logic unused_wbits;

  assign wr_choice    = we && (addr == A_CHOICE);
  assign wr_poll      = we && (addr == A_POLL);
  assign wr_cmd       = we && (addr == A_CMD);
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_o      <= '0;
      rel_o      <= REL_NONE;
      guar_o     <= 1'b0;
      interval_o <= '0;
      go_o       <= 1'b0;
    end else begin
      go_o <= wr_choice;
      if (wr_choice) begin
        key_o  <= wdata[KEY_W-1:0];
        rel_o  <= (wdata[9:8] == 2'b11) ? REL_TOLERANT : wdata[9:8];
        guar_o <= wdata[12];
      end
      if (wr_poll) interval_o <= wdata[POLL_W-1:0];
    end
  end

  assign run_o     = wr_cmd && wdata[0];
  assign stop_o    = wr_cmd && wdata[1];
  assign release_o = wr_cmd && wdata[2];

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CHOICE: begin
        rdata[KEY_W-1:0] = key_o;
        rdata[9:8]       = rel_o;
        rdata[12]        = guar_o;
      end
      A_POLL:   rdata[POLL_W-1:0] = interval_o;
      A_CMD:    rdata = '0;
      default:  rdata = status_in;
    endcase
  end

  p_rel_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rel_o != 2'b11);
endmodule

// File: rtl/alc_poll_timer.sv
module alc_poll_timer #(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [POLL_W-1:0] interval,
  output logic              tick
);
  localparam logic [POLL_W-1:0] ONE = POLL_W'(1);
  logic [POLL_W-1:0] cnt_q;

  assign tick = en && (interval != '0) && (cnt_q == interval - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!en || tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + ONE;
  end

  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/alc_cfg_sel.sv
module alc_cfg_sel
  import accel_life_pkg::*;
#(
  parameter  int KEY_W = 2,
  localparam int CFG_W = KEY_W + 3
) (
  input  logic [KEY_W-1:0] key,
  input  logic [1:0]       rel,
  input  logic             guar,
  input  logic             eco_need,
  input  logic             batt_low,
  input  logic             chan_low,
  input  logic [1:0]       atk,
  input  logic [CFG_W-1:0] sec_cfg,
  output logic [CFG_W-1:0] perf_idx,
  output logic [CFG_W-1:0] sec_idx,
  output logic [3:0]       perm
);
  assign perf_idx = {rel, key, (!guar && eco_need)};
  assign sec_idx  = (atk == ATK_DOS) ? {REL_TOLERANT, sec_cfg[KEY_W:0]} : sec_cfg;
  assign perm     = {!batt_low, !batt_low, 1'b1, !(batt_low || chan_low)};
endmodule

// File: rtl/accel_life_ctrl.sv
module accel_life_ctrl
  import accel_life_pkg::*;
#(
  parameter  int KEY_W  = 2,
  parameter  int POLL_W = 16,
  localparam int CFG_W  = KEY_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [1:0]       host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  output logic             mon_req,
  input  logic             mon_ack,
  input  logic             mon_batt_low,
  input  logic             mon_chan_low,
  input  logic             sec_evt,
  input  logic [1:0]       sec_class,
  input  logic [CFG_W-1:0] sec_cfg,
  output logic             rcfg_start,
  output logic [CFG_W-1:0] rcfg_idx,
  input  logic             rcfg_done,
  output logic             io_stall
);
  life_state_e      state_q, state_d;
  logic             launch_q, launch_d;
  logic [CFG_W-1:0] pend_q, pend_d, active_q, active_d;
  logic             stall_q, stall_d, low_q, low_d, pwait_q, pwait_d;
  logic [3:0]       perm_q, perm_d;

  logic [KEY_W-1:0]  key;
  logic [1:0]        rel;
  logic              guar, go, run_cmd, stop_cmd, rel_cmd, tick, eco_now;
  logic [POLL_W-1:0] interval;
  logic [CFG_W-1:0]  perf_idx, sec_idx;
  logic [3:0]        perm_w;
  logic [31:0]       status_w;

  always_comb begin
    status_w              = '0;
    status_w[2:0]         = state_q;
    status_w[8 +: CFG_W]  = active_q;
    status_w[27:24]       = perm_q;
    status_w[31]          = stall_q;
  end

  alc_regs #(.KEY_W(KEY_W), .POLL_W(POLL_W), .DATA_W(32)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr), .wdata(host_wdata),
    .status_in(status_w), .rdata(host_rdata), .key_o(key), .rel_o(rel),
    .guar_o(guar), .interval_o(interval), .go_o(go), .run_o(run_cmd),
    .stop_o(stop_cmd), .release_o(rel_cmd)
  );

  alc_poll_timer #(.POLL_W(POLL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en((state_q == ST_RUN) && !pwait_q),
    .interval(interval), .tick(tick)
  );

  assign eco_now = mon_ack ? (mon_batt_low || mon_chan_low) : low_q;

  alc_cfg_sel #(.KEY_W(KEY_W)) u_sel (
    .key(key), .rel(rel), .guar(guar), .eco_need(eco_now),
    .batt_low(mon_batt_low), .chan_low(mon_chan_low), .atk(sec_class),
    .sec_cfg(sec_cfg), .perf_idx(perf_idx), .sec_idx(sec_idx), .perm(perm_w)
  );

  assign mon_req    = (state_q == ST_INIT_Q) || ((state_q == ST_RUN) && pwait_q);
  assign rcfg_start = launch_q;
  assign rcfg_idx   = pend_q;
  assign io_stall   = stall_q;

  always_comb begin
    state_d  = state_q;
    launch_d = 1'b0;
    pend_d   = pend_q;
    active_d = active_q;
    stall_d  = stall_q && !rel_cmd;
    perm_d   = perm_q;
    low_d    = low_q;
    pwait_d  = pwait_q;
    if (mon_req && mon_ack) begin
      perm_d = perm_w;
      low_d  = mon_batt_low || mon_chan_low;
    end
    if (sec_evt) begin
      state_d  = ST_CFG;
      launch_d = 1'b1;
      pend_d   = sec_idx;
      pwait_d  = 1'b0;
      if (sec_class == ATK_EXTRACT) stall_d = 1'b1;
    end else begin
      unique case (state_q)
        ST_INIT_Q: if (mon_ack) state_d = ST_INIT_W;
        ST_INIT_W, ST_STOP: begin
          if (go) begin
            state_d  = ST_CFG;
            launch_d = 1'b1;
            pend_d   = perf_idx;
          end else if (run_cmd && (state_q == ST_STOP)) begin
            state_d = ST_RUN;
          end
        end
        ST_CFG: begin
          if (rcfg_done && !launch_q) begin
            state_d  = ST_RUN;
            active_d = pend_q;
          end
        end
        ST_RUN: begin
          if (stop_cmd) begin
            state_d = ST_STOP;
            pwait_d = 1'b0;
          end else if (pwait_q && mon_ack) begin
            pwait_d = 1'b0;
            if (perf_idx != active_q) begin
              state_d  = ST_CFG;
              launch_d = 1'b1;
              pend_d   = perf_idx;
            end
          end else if (tick) begin
            pwait_d = 1'b1;
          end
        end
        default: state_d = ST_INIT_Q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_INIT_Q;
      launch_q <= 1'b0;
      pend_q   <= '0;
      active_q <= '0;
      stall_q  <= 1'b0;
      perm_q   <= '0;
      low_q    <= 1'b0;
      pwait_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      launch_q <= launch_d;
      pend_q   <= pend_d;
      active_q <= active_d;
      stall_q  <= stall_d;
      perm_q   <= perm_d;
      low_q    <= low_d;
      pwait_q  <= pwait_d;
    end
  end

  p_start_in_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rcfg_start |-> (state_q == ST_CFG));
  p_done_to_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CFG && rcfg_done && !rcfg_start && !sec_evt)
    |=> (state_q == ST_RUN && active_q == $past(pend_q)));
  p_init_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INIT_Q && mon_ack && !sec_evt) |=> (state_q == ST_INIT_W && !mon_req));
  p_sec_preempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> (state_q == ST_CFG && rcfg_start));
  p_dos_tolerant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && sec_class == ATK_DOS) |=> (rcfg_idx[CFG_W-1:CFG_W-2] == REL_TOLERANT));
  p_extract_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && sec_class == ATK_EXTRACT) |=> io_stall);
  p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && !sec_evt && !go) |=> !rcfg_start);
endmodule

// File: tb/test_accel_life_ctrl.sv
`timescale 1ns/1ps
module test_accel_life_ctrl;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_we;
  logic [1:0]    host_addr;
  logic [31:0]   host_wdata, host_rdata;
  logic          mon_req, mon_ack, mon_batt_low, mon_chan_low;
  logic          sec_evt;
  logic [1:0]    sec_class;
  logic [CW-1:0] sec_cfg, rcfg_idx;
  logic          rcfg_start, rcfg_done, io_stall;

  int n_chk = 0;
  int n_err = 0;
  logic [CW-1:0] exp_q[$];
  logic [31:0]   st;

  always #2.5 clk = ~clk;

  accel_life_ctrl i_accel_life_ctrl (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mon_req(mon_req),
    .mon_ack(mon_ack), .mon_batt_low(mon_batt_low), .mon_chan_low(mon_chan_low),
    .sec_evt(sec_evt), .sec_class(sec_class), .sec_cfg(sec_cfg),
    .rcfg_start(rcfg_start), .rcfg_idx(rcfg_idx), .rcfg_done(rcfg_done),
    .io_stall(io_stall)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each launch must match the next expected index
  always @(negedge clk) begin
    if (rst_n && rcfg_start) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected launch", {27'd0, rcfg_idx}, 32'hffff);
      else begin
        logic [CW-1:0] e;
        e = exp_q.pop_front();
        chk(rcfg_idx == e, "R3 launch index", {27'd0, rcfg_idx}, {27'd0, e});
      end
    end
  end

  task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0; host_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    host_addr = a; #1; v = host_rdata;
  endtask

  task automatic finish_cfg();
    repeat (2) @(negedge clk);
    rcfg_done = 1'b1;
    @(negedge clk); rcfg_done = 1'b0;
  endtask

  task automatic mon_answer(input logic b, input logic c);
    bit seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (mon_req) seen = 1;
    end
    chk(seen, "R4 monitor request seen", {31'd0, seen}, 1);
    mon_ack = 1'b1; mon_batt_low = b; mon_chan_low = c;
    @(negedge clk); mon_ack = 1'b0; mon_batt_low = 1'b0; mon_chan_low = 1'b0;
  endtask

  task automatic sec_pulse(input logic [1:0] cls, input logic [CW-1:0] cfg);
    @(negedge clk); sec_evt = 1'b1; sec_class = cls; sec_cfg = cfg;
    @(negedge clk); sec_evt = 1'b0;
  endtask

  initial begin
    #1000000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_we = 0; host_addr = 0; host_wdata = 0; mon_ack = 0;
    mon_batt_low = 0; mon_chan_low = 0; sec_evt = 0; sec_class = 0; sec_cfg = 0;
    rcfg_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 and R13 reset state
    rd(2'd3, st);
    chk(st == 32'h0, "R1 status after reset", st, 0);
    chk(mon_req && !rcfg_start && !io_stall, "R1 outputs after reset",
        {29'd0, mon_req, rcfg_start, io_stall}, 32'h4);

    // R2 init query, channel low
    mon_answer(1'b0, 1'b1);
    rd(2'd3, st);
    chk(st[2:0] == 3'd1, "R2 state awaiting choice", st[2:0], 1);
    chk(st[27:24] == 4'b1110, "R2 permitted mask", st[27:24], 4'b1110);
    chk(!mon_req, "R2 request dropped", mon_req, 0);

    // R3 choice: key 2, rel 1, best effort -> {01,10,1}
    host_wr(2'd1, 32'd4);
    exp_q.push_back(5'b01101);
    host_wr(2'd0, 32'h0000_0102);
    @(negedge clk);
    rd(2'd3, st);
    chk(st[2:0] == 3'd2, "R3 state configuring", st[2:0], 2);
    finish_cfg();
    rd(2'd3, st);
    chk(st[2:0] == 3'd3 && st[12:8] == 5'b01101, "R13 status run and active", st, 32'h0E00_0D03);

    // R4 poll interval 4
    repeat (3) @(negedge clk);
    #1 chk(!mon_req, "R4 no request before interval", mon_req, 0);
    @(negedge clk);
    #1 chk(mon_req, "R4 request at interval", mon_req, 1);

    // R5 upgrade then downgrade
    exp_q.push_back(5'b01100);
    mon_answer(1'b0, 1'b0);
    finish_cfg();
    exp_q.push_back(5'b01101);
    mon_answer(1'b1, 1'b0);
    finish_cfg();
    rd(2'd3, st);
    chk(st[12:8] == 5'b01101, "R5 downgraded active", st[12:8], 5'b01101);

    // R6 guaranteed policy
    host_wr(2'd0, 32'h0000_1102);
    exp_q.push_back(5'b01100);
    mon_answer(1'b1, 1'b0);
    finish_cfg();
    mon_answer(1'b1, 1'b0);
    rd(2'd3, st);
    chk(st[2:0] == 3'd3 && st[12:8] == 5'b01100, "R6 kept in run", st, 32'h0C03);

    // R7 stop and resume
    host_wr(2'd2, 32'd2);
    rd(2'd3, st);
    chk(st[2:0] == 3'd4, "R7 stop state", st[2:0], 4);
    repeat (10) @(negedge clk);
    host_wr(2'd2, 32'd1);
    rd(2'd3, st);
    chk(st[2:0] == 3'd3 && st[12:8] == 5'b01100, "R7 resumed without reload", st, 32'h0C03);

    // R8 hijack, then R12 policy re-applied
    exp_q.push_back(5'b00110);
    sec_pulse(2'd0, 5'b00110);
    rd(2'd3, st);
    chk(st[2:0] == 3'd2, "R8 security enters configuring", st[2:0], 2);
    finish_cfg();
    rd(2'd3, st);
    chk(st[12:8] == 5'b00110, "R8 hijack index active", st[12:8], 5'b00110);
    exp_q.push_back(5'b01100);
    mon_answer(1'b0, 1'b0);
    finish_cfg();
    rd(2'd3, st);
    chk(st[12:8] == 5'b01100, "R12 policy re-applied", st[12:8], 5'b01100);

    // R9 DoS from stop, R8 preempting a pending reload
    host_wr(2'd2, 32'd2);
    exp_q.push_back(5'b10011);
    sec_pulse(2'd1, 5'b00011);
    exp_q.push_back(5'b00100);
    sec_pulse(2'd0, 5'b00100);
    finish_cfg();
    rd(2'd3, st);
    chk(st[12:8] == 5'b00100 && st[2:0] == 3'd3, "R8 preempted reload", st, 32'h0403);

    // R10 extraction stall
    exp_q.push_back(5'b00010);
    sec_pulse(2'd2, 5'b00010);
    chk(io_stall, "R10 stall raised", io_stall, 1);
    finish_cfg();
    chk(io_stall, "R10 stall held after reload", io_stall, 1);
    host_wr(2'd2, 32'd4);
    chk(!io_stall, "R10 stall released", io_stall, 0);

    // R11 reliability clamp
    host_wr(2'd2, 32'd2);
    exp_q.push_back(5'b10000);
    host_wr(2'd0, 32'h0000_1300);
    rd(2'd0, st);
    chk(st[9:8] == 2'd2, "R11 reliability clamped", st[9:8], 2);
    finish_cfg();
    rd(2'd3, st);
    chk(st[12:8] == 5'b10000, "R11 clamped index active", st[12:8], 5'b10000);

    // R4 interval 0 disables polling; R8 priority over stop
    host_wr(2'd1, 32'd0);
    repeat (30) @(negedge clk);
    #1 chk(!mon_req, "R4 polling disabled", mon_req, 0);
    exp_q.push_back(5'b00111);
    @(negedge clk);
    sec_evt = 1'b1; sec_class = 2'd0; sec_cfg = 5'b00111;
    host_we = 1'b1; host_addr = 2'd2; host_wdata = 32'd2;
    @(negedge clk);
    sec_evt = 1'b0; host_we = 1'b0;
    rd(2'd3, st);
    chk(st[2:0] == 3'd2, "R8 security beats stop", st[2:0], 2);
    finish_cfg();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected launches seen", exp_q.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule